// File: doc/BRIEF.md
# Channel Interrupt Mask Bank

This block holds the interrupt enable bits for up to 96 converter channels, arranged as three 32-bit registers on a simple register bus. A 96-bit elaboration parameter decides, channel by channel, whether a mask bit exists at all. Bits that do not exist have no flip-flop, read back as zero and ignore writes. A register whose 32 bits are all absent is treated as reserved space, and any access to it returns a bus error.

The block takes a 96-bit vector of per-channel pending flags. It ANDs each flag with its mask bit to give a per-channel request. The OR of all requests drives one interrupt line, which is registered. Bus responses come one cycle after the access: read data and the error flag are both registered.

Top module: `chan_mask_bank`

## Requirements
- R1: After reset every mask bit is 0, so req_o is all zero, and irq_o, rdata_o and err_o are 0.
- R2: Register k (k = 0, 1, 2) sits at byte offset 0x024 + 4k and holds channel 32k + b at bit b. A write stores wdata_i in that register. A read returns the stored word on rdata_o in the cycle after the read strobe.
- R3: For a channel whose implementation bit is 0, the mask bit always reads 0 and writes to it are ignored. An access to an implemented register raises no error, even if it writes absent bits.
- R4: An access to a register whose 32 implementation bits are all 0 gives err_o = 1 and rdata_o = 0 in the next cycle, and it changes no stored mask bit.
- R5: req_o[i] equals pend_i[i] AND mask bit i, combinationally. A mask bit of 1 enables channel i.
- R6: irq_o is the OR of all bits of req_o, delayed by one clock.
- R7: Nothing is stored and no error is raised when sel_i is 0 or when the address is not one of the three register offsets. In that case rdata_o is 0 in the next cycle.
- R8: rdata_o is 0 in any cycle that does not follow an accepted read of a present register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| sel_i | input | 1 | Bank select from the address decoder |
| addr_i | input | 12 | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read |
| err_o | output | 1 | Transfer error, valid the cycle after the access |
| pend_i | input | 96 | Per-channel pending flags |
| req_o | output | 96 | Masked per-channel requests |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
A mask write and a change of the pending flags can land on the same clock edge. At that edge, the combined interrupt must still sample the old mask. The bench provokes this by driving a pending flag in the same cycle as a write that enables that channel. It then expects req_o to rise right after the edge and irq_o to rise only one edge later. The reverse case is also covered: clearing the mask while the flag stays high must drop irq_o exactly one cycle after req_o drops.

// File: rtl/chmask_pkg.sv
package chmask_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_REG = 3;
  localparam int unsigned NUM_CH  = REG_W * NUM_REG;
  localparam int unsigned ADDR_W  = 12;

  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/chmask_rst_sync.sv
module chmask_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/chmask_decode.sv
module chmask_decode #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_REG = 3,
  parameter int unsigned REG_W   = 32,
  parameter logic [ADDR_W-1:0] BASE = 12'h024,
  parameter logic [NUM_REG*REG_W-1:0] IMPL = '1
) (
  input  logic               sel_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [NUM_REG-1:0] wr_hit_o,
  output logic [NUM_REG-1:0] rd_hit_o,
  output logic               err_o
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_REG);

  logic [NUM_REG-1:0] present;
  logic [NUM_REG-1:0] match;
  logic [ADDR_W-1:0]  off;
  logic               access;

  assign off    = addr_i - BASE;
  assign access = sel_i & (wr_i | rd_i);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    assign present[r]  = |IMPL[r*REG_W +: REG_W];
    assign match[r]    = (addr_i >= BASE) && (off < SPAN) && (off == ADDR_W'(4 * r));
    assign wr_hit_o[r] = access & wr_i & match[r] & present[r];
    assign rd_hit_o[r] = access & rd_i & match[r] & present[r];
  end

  assign err_o = access & (|(match & ~present));
endmodule

// File: rtl/chmask_reg.sv
module chmask_reg #(
  parameter int unsigned REG_W = 32,
  parameter logic [REG_W-1:0] KEEP = '1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (KEEP[b]) begin : g_ff
      logic bit_q, bit_d;
      always_comb bit_d = we_i ? wdata_i[b] : bit_q;
      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) bit_q <= 1'b0;
        else          bit_q <= bit_d;
      end
      assign q_o[b] = bit_q;
    end else begin : g_none
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/chmask_combine.sv
module chmask_combine #(
  parameter int unsigned NUM_CH = 96
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] req_o,
  output logic              irq_o
);
  logic irq_d, irq_q;

  assign req_o = pend_i & mask_i;
  always_comb irq_d = |req_o;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R6: the interrupt line trails the request vector by exactly one cycle
  p_irq_lag_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    1'b1 |=> (irq_o == $past(|req_o)));
endmodule

// File: rtl/chan_mask_bank.sv
module chan_mask_bank
  import chmask_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 12'h024,
  parameter logic [NUM_CH-1:0] IMPL = {32'h0000_0000, 32'h0000_FF0F, 32'hFFFF_FFFF}
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              err_o,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] req_o,
  output logic              irq_o
);
  logic                              rst_n;
  logic [NUM_REG-1:0]                wr_hit, rd_hit;
  logic                              err_d, err_q;
  logic [NUM_REG-1:0][REG_W-1:0]     words;
  logic [NUM_CH-1:0]                 mask_all;
  word_t                             rdata_d, rdata_q;

  chmask_rst_sync u_rst (.clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n));

  chmask_decode #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .REG_W(REG_W),
                  .BASE(BASE), .IMPL(IMPL)) u_dec (
    .sel_i(sel_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wr_hit_o(wr_hit), .rd_hit_o(rd_hit), .err_o(err_d));

  for (genvar r = 0; r < NUM_REG; r++) begin : g_bank
    chmask_reg #(.REG_W(REG_W), .KEEP(IMPL[r*REG_W +: REG_W])) u_reg (
      .clk_i(clk_i), .rst_n_i(rst_n), .we_i(wr_hit[r]),
      .wdata_i(wdata_i), .q_o(words[r]));
    assign mask_all[r*REG_W +: REG_W] = words[r];
  end

  always_comb begin
    rdata_d = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (rd_hit[r]) rdata_d = words[r];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  chmask_combine #(.NUM_CH(NUM_CH)) u_comb (
    .clk_i(clk_i), .rst_n_i(rst_n), .pend_i(pend_i), .mask_i(mask_all),
    .req_o(req_o), .irq_o(irq_o));

  // R4: an error response carries no data
  p_err_nodata_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q |-> (rdata_q == '0));
  // R4: an erroring access leaves the stored masks untouched
  p_err_nochange_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_q |-> $stable(mask_all));
  // R7: a deselected cycle yields no error
  p_desel_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sel_i |=> !err_q);
  // R8: nonzero data only follows a read strobe
  p_data_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(sel_i && rd_i) |=> (rdata_q == '0));
  // R3: absent channels never show a request
  p_absent_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((req_o & ~IMPL) == '0));
endmodule

// File: tb/chan_mask_bank_tb.sv
module chan_mask_bank_tb_top;
  localparam time PERIOD = 10ns;

  typedef struct packed {
    logic [1:0]  op;     // 1 write, 2 read
    logic        sel;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b1, 12'h024, 32'h0,         32'h0,         1'b0}, // R1 reset value
    '{2'd1, 1'b1, 12'h024, 32'hA5A5_5A5A, 32'h0,         1'b0}, // R8 write gives no data
    '{2'd2, 1'b1, 12'h024, 32'h0,         32'hA5A5_5A5A, 1'b0}, // R2
    '{2'd1, 1'b1, 12'h028, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R3 no error
    '{2'd2, 1'b1, 12'h028, 32'h0,         32'h0000_FF0F, 1'b0}, // R3 absent bits 0
    '{2'd1, 1'b1, 12'h02C, 32'h1234_5678, 32'h0,         1'b1}, // R4 write error
    '{2'd2, 1'b1, 12'h02C, 32'h0,         32'h0,         1'b1}, // R4 read error
    '{2'd1, 1'b1, 12'h030, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R7 foreign offset
    '{2'd1, 1'b0, 12'h024, 32'h0,         32'h0,         1'b0}, // R7 deselected
    '{2'd2, 1'b1, 12'h024, 32'h0,         32'hA5A5_5A5A, 1'b0}, // R7 unchanged
    '{2'd2, 1'b1, 12'h028, 32'h0,         32'h0000_FF0F, 1'b0}, // R4 unchanged
    '{2'd1, 1'b1, 12'h028, 32'h0000_0100, 32'h0,         1'b0}, // R2
    '{2'd2, 1'b1, 12'h028, 32'h0,         32'h0000_0100, 1'b0}, // R2
    '{2'd2, 1'b1, 12'h020, 32'h0,         32'h0,         1'b0}  // R7 below base
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        err, irq;
  logic [95:0] pend, req;
  int          checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  chan_mask_bank dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .sel_i(sel), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .pend_i(pend), .req_o(req), .irq_o(irq));

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] op, input logic s, input logic [11:0] a,
                     input logic [31:0] d);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr = (op == 2'd1); rd = (op == 2'd2);
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 0; wr = 0; rd = 0; addr = '0; wdata = '0; pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", 96'(rdata), 96'h0);
    chk("R1 err", 96'(err), 96'h0);
    chk("R1 irq", 96'(irq), 96'h0);
    pend = '1; #1;
    chk("R1 req with all pending", req, 96'h0);
    pend = '0;

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].op, VEC[i].sel, VEC[i].addr, VEC[i].wdata);
      chk($sformatf("R2/R3/R4/R7/R8 vec%0d rdata", i), 96'(rdata), 96'(VEC[i].exp_rd));
      chk($sformatf("R4/R7 vec%0d err", i), 96'(err), 96'(VEC[i].exp_err));
    end

    // R5: reg0 = A5A5_5A5A, reg1 = 0000_0100
    @(negedge clk) pend = 96'h0000_0000_0000_0103_0000_0003;
    #1 chk("R5 req gated", req, 96'h0000_0000_0000_0100_0000_0002);
    @(posedge clk); #1;
    chk("R6 irq set", 96'(irq), 96'h1);
    @(negedge clk) pend = 96'h1;
    #1 chk("R5 masked off", req, 96'h0);
    @(posedge clk); #1;
    chk("R6 irq clear", 96'(irq), 96'h0);

    // same-cycle: enable channel 0 on the edge that sees it pending
    @(negedge clk);
    pend = 96'h1; sel = 1; wr = 1; addr = 12'h024; wdata = 32'h0000_0001;
    @(posedge clk); #1;
    sel = 0; wr = 0;
    chk("R5 req after write", req, 96'h1);
    chk("R6 irq still old", 96'(irq), 96'h0);
    @(posedge clk); #1;
    chk("R6 irq follows", 96'(irq), 96'h1);
    bus(2'd1, 1'b1, 12'h024, 32'h0);
    chk("R5 req dropped", req, 96'h0);
    chk("R6 irq lags drop", 96'(irq), 96'h1);
    @(posedge clk); #1;
    chk("R6 irq dropped", 96'(irq), 96'h0);

    // R1: reset mid-run clears masks
    bus(2'd1, 1'b1, 12'h024, 32'hFFFF_FFFF);
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1 async clear", req, 96'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    bus(2'd2, 1'b1, 12'h024, 32'h0);
    chk("R1 mask zero after reset", 96'(rdata), 96'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule